// File: doc/BRIEF.md
# Serial Radio Packet Receive Deframer

This block takes the serial bitstream that an external radio delivers once it has matched a frame delimiter and turns it into payload bytes in a receive FIFO. The radio supplies a data clock, a data line and a one-period start flag. The block samples the data line on each rising edge of the data clock and collects, most significant bit first, a length byte, that many payload bytes and a two-byte CRC16. While a frame is in progress it drives a hold level back to the radio.

Payload bytes go into the FIFO as they arrive, but they stay invisible to the reader until the frame is judged good. A good frame has a zero CRC remainder, passes the optional address filter and did not overflow the FIFO. A good frame becomes readable at once and raises a receive interrupt. A frame that fails any test is removed by moving the write pointer back to where the frame began. The reader pops bytes through a show-ahead port and sees a count of readable bytes.

Top module: `rx_deframer`

## Requirements
- R1: After reset, `radio_hold`, `rx_irq` and `rx_ovf` are low and `fifo_count` is 0.
- R2: While idle, a high `radio_flag` at a rising edge of `radio_clk` starts a frame. Later rising edges deliver data bits, most significant bit first. `radio_hold` stays high from the start until the frame ends or aborts. It is low when idle.
- R3: A length byte of 0 or above 127 aborts the frame at once. `radio_hold` returns low, nothing is stored and `rx_irq` stays low.
- R4: The CRC uses polynomial x^16+x^12+x^5+1 with an initial value of 0. It runs over the length byte, the payload and the two CRC bytes, which are sent high byte first. A nonzero remainder discards the frame: the count is unchanged and no interrupt is raised.
- R5: When `addr_en` is high, the first payload byte must equal `addr_val` or the frame is discarded. When `addr_en` is low, any first byte is accepted.
- R6: An accepted frame stores only its payload bytes, in arrival order. It raises `fifo_count` by the length and sets `rx_irq`.
- R7: A payload byte that arrives while the FIFO is full sets `rx_ovf`, and the whole frame is discarded.
- R8: `rd_data` shows the oldest readable byte. `rd_en` pops one byte per cycle when `fifo_count` is nonzero. `fifo_count` counts committed bytes only.
- R9: A one-cycle pulse on `irq_clr` clears both `rx_irq` and `rx_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| radio_clk | input | 1 | Radio data clock, already synchronous to clk and much slower |
| radio_data | input | 1 | Serial receive data |
| radio_flag | input | 1 | Delimiter-match pulse from the radio |
| radio_hold | output | 1 | Frame-in-progress acknowledge to the radio |
| addr_en | input | 1 | Enables the first-byte address filter |
| addr_val | input | W | Address the first payload byte must match |
| rd_en | input | 1 | Pops one FIFO byte |
| rd_data | output | W | Oldest readable FIFO byte |
| fifo_count | output | AW+1 | Number of readable bytes |
| irq_clr | input | 1 | Clears the interrupt and overflow flags |
| rx_irq | output | 1 | Frame-received flag |
| rx_ovf | output | 1 | FIFO overflow flag |

## Verification
The assertions assume that `radio_clk` is already synchronous to `clk` and that each of its phases lasts several system cycles, so at most one rising edge falls in any cycle. They also assume that `radio_flag` does not matter outside the idle state. The bench drives the data clock in phases of four system cycles. It changes the data and flag lines only while the data clock is low, and it raises the flag only between frames. It pops the FIFO only between frames, so a read never overlaps a commit.

// File: rtl/rxd_pkg.sv
// Shared types and the CRC step for the receive deframer.
package rxd_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LEN, ST_PAY, ST_CRC} rx_state_t;

    localparam logic [15:0] CRC_POLY = 16'h1021;

    // One serial CRC step: shift in a single bit, MSB-first convention.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction
endpackage

// File: rtl/rxd_bitcap.sv
// Bit capture: finds rising edges of the radio data clock and shifts data
// bits into bytes, MSB first. Assumes radio_clk is synchronous to clk and
// holds each level for at least two cycles. byte_stb is registered, so it
// rises in the cycle after the edge that carried the last bit.
module rxd_bitcap #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dclk,
    input  logic         din,
    input  logic         en,
    input  logic         clr,
    output logic         rise,
    output logic         bit_stb,
    output logic         byte_stb,
    output logic [W-1:0] byte_val
);
    logic          dclk_q;
    logic [CW-1:0] cnt;
    logic [W-2:0]  sh;

    assign rise    = dclk & ~dclk_q;
    assign bit_stb = rise & en;

    // Edge history, bit counter and byte assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_q   <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            dclk_q   <= dclk;
            byte_stb <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else if (bit_stb) begin
                sh  <= {sh[W-3:0], din};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W-1)) begin
                    byte_stb <= 1'b1;
                    byte_val <= {sh, din};
                end
            end
        end
    end
endmodule

// File: rtl/rxd_crc.sv
// Serial CRC16 accumulator. It clears to zero and folds in one bit per strobe.
// The remainder is zero after a good frame, including its CRC bytes.
module rxd_crc import rxd_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        stb,
    input  logic        din,
    output logic [15:0] crc
);
    // Remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc <= '0;
        else if (clr)    crc <= '0;
        else if (stb)    crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/rxd_fifo.sv
// Receive FIFO with a tentative write pointer. Writes advance wr_ptr.
// commit publishes them to the reader. rewind throws them away. The count
// and the show-ahead read cover committed data only. Assumes that writes
// stop when full and that commit and rewind never arrive together.
module rxd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         commit,
    input  logic         rewind,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic [AW:0]  count,
    output logic         full
);
    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, wr_base, rd_ptr;

    assign count   = wr_base - rd_ptr;
    assign full    = (wr_ptr - rd_ptr) == (AW+1)'(DEPTH);
    assign rd_data = mem[rd_ptr[AW-1:0]];

    // Storage array; no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Pointer updates: tentative write, commit/rewind, read pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wr_base <= '0;
            rd_ptr  <= '0;
        end else begin
            if (rewind)     wr_ptr <= wr_base;
            else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (commit)     wr_base <= wr_ptr;
            if (rd_en && count != '0) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    assert_commit_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && rewind));
endmodule

// File: rtl/rx_deframer.sv
// Receive deframer top. A flag at a data-clock edge starts a frame. The
// frame then passes through the length, payload and CRC states. Payload is
// written tentatively and committed or rewound once the second CRC byte has
// arrived. Assumes radio_flag matters only while idle.
module rx_deframer import rxd_pkg::*; #(
    parameter int W       = 8,
    parameter int DEPTH   = 64,
    parameter int LEN_MAX = 127,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         radio_clk,
    input  logic         radio_data,
    input  logic         radio_flag,
    output logic         radio_hold,
    input  logic         addr_en,
    input  logic [W-1:0] addr_val,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic [AW:0]  fifo_count,
    input  logic         irq_clr,
    output logic         rx_irq,
    output logic         rx_ovf
);
    rx_state_t    state;
    logic [W-1:0] len_q, pay_idx;
    logic         crc_idx, addr_bad, ovf_seen;
    logic         rise, bit_stb, byte_stb, full;
    logic [W-1:0] byte_val;
    logic [15:0]  crc;
    logic         start, len_bad, wr_en, end_frame, good, commit, rewind;

    assign start     = (state == ST_IDLE) && rise && radio_flag;
    assign len_bad   = (byte_val == '0) || (byte_val > W'(LEN_MAX));
    assign wr_en     = (state == ST_PAY) && byte_stb && !full;
    assign end_frame = (state == ST_CRC) && byte_stb && crc_idx;
    assign good      = end_frame && (crc == 16'h0000) && !addr_bad && !ovf_seen;
    assign commit    = good;
    assign rewind    = end_frame && !good;

    rxd_bitcap #(.W(W)) u_bitcap (
        .clk(clk), .rst_n(rst_n), .dclk(radio_clk), .din(radio_data),
        .en(state != ST_IDLE), .clr(start), .rise(rise), .bit_stb(bit_stb),
        .byte_stb(byte_stb), .byte_val(byte_val)
    );

    rxd_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clr(start), .stb(bit_stb),
        .din(radio_data), .crc(crc)
    );

    rxd_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(byte_val),
        .commit(commit), .rewind(rewind), .rd_en(rd_en), .rd_data(rd_data),
        .count(fifo_count), .full(full)
    );

    // Frame sequencing through the length, payload and CRC fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            len_q    <= '0;
            pay_idx  <= '0;
            crc_idx  <= 1'b0;
            addr_bad <= 1'b0;
            ovf_seen <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_LEN;
                    addr_bad <= 1'b0;
                    ovf_seen <= 1'b0;
                end
                ST_LEN: if (byte_stb) begin
                    len_q   <= byte_val;
                    pay_idx <= '0;
                    state   <= len_bad ? ST_IDLE : ST_PAY;
                end
                ST_PAY: if (byte_stb) begin
                    if (full) ovf_seen <= 1'b1;
                    if (pay_idx == '0 && addr_en && byte_val != addr_val)
                        addr_bad <= 1'b1;
                    pay_idx <= pay_idx + 1'b1;
                    if (pay_idx == len_q - W'(1)) begin
                        state   <= ST_CRC;
                        crc_idx <= 1'b0;
                    end
                end
                ST_CRC: if (byte_stb) begin
                    crc_idx <= 1'b1;
                    if (crc_idx) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Hold level to the radio for the life of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                            radio_hold <= 1'b0;
        else if (start)                                        radio_hold <= 1'b1;
        else if (end_frame || (state == ST_LEN && byte_stb && len_bad)) radio_hold <= 1'b0;
    end

    // Sticky interrupt and overflow flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_irq <= 1'b0;
            rx_ovf <= 1'b0;
        end else begin
            if (commit)       rx_irq <= 1'b1;
            else if (irq_clr) rx_irq <= 1'b0;
            if (state == ST_PAY && byte_stb && full) rx_ovf <= 1'b1;
            else if (irq_clr)                        rx_ovf <= 1'b0;
        end
    end

    assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> radio_hold);
    assert_len_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEN && byte_stb && len_bad) |=> (!radio_hold && state == ST_IDLE));
    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(crc == 16'h0000));
    assert_idle_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE) || radio_hold);
endmodule

// File: tb/rx_deframer_bench.sv
`timescale 1ns/1ps
module rx_deframer_bench;
    localparam int W = 8, DEPTH = 64, AW = $clog2(DEPTH);

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] seed;
        logic       aen;
        logic       badcrc;
        logic       keep;
    } vec_t;

    // Frame vectors: length, first byte seed, address filter, corrupt CRC, expected keep.
    localparam vec_t VECS [6] = '{
        '{8'd4,  8'h10, 1'b0, 1'b0, 1'b1},
        '{8'd1,  8'h33, 1'b0, 1'b0, 1'b1},
        '{8'd5,  8'h20, 1'b0, 1'b1, 1'b0},
        '{8'd3,  8'hA5, 1'b1, 1'b0, 1'b1},
        '{8'd3,  8'h5A, 1'b1, 1'b0, 1'b0},
        '{8'd20, 8'h01, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic radio_clk = 1'b0, radio_data = 1'b0, radio_flag = 1'b0;
    logic addr_en = 1'b0, rd_en = 1'b0, irq_clr = 1'b0;
    logic [W-1:0] addr_val = 8'hA5;
    logic radio_hold, rx_irq, rx_ovf;
    logic [W-1:0] rd_data;
    logic [AW:0] fifo_count;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    rx_deframer u_rx_deframer (
        .clk(clk), .rst_n(rst_n), .radio_clk(radio_clk), .radio_data(radio_data),
        .radio_flag(radio_flag), .radio_hold(radio_hold), .addr_en(addr_en),
        .addr_val(addr_val), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_count(fifo_count), .irq_clr(irq_clr), .rx_irq(rx_irq), .rx_ovf(rx_ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pb(input logic [7:0] seed, input int i);
        return seed + 8'(i * 13);
    endfunction

    function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] v);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ v[i];
            r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return r;
    endfunction

    task automatic dclk_pulse();
        repeat (4) @(negedge clk);
        radio_clk = 1'b1;
        repeat (4) @(negedge clk);
        radio_clk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            radio_data = v[i];
            dclk_pulse();
        end
    endtask

    // Flag, length byte, payload and CRC; stops after the length byte if it is illegal.
    task automatic send_frame(input logic [7:0] len, input logic [7:0] seed, input logic badcrc);
        logic [15:0] c = 16'h0000;
        logic ok = (len != 0) && (len <= 127);
        radio_data = 1'b1;
        radio_flag = 1'b1;
        dclk_pulse();
        radio_flag = 1'b0;
        c = crc_bits(c, len);
        send_byte(len);
        @(negedge clk);
        check(ok ? "R2 hold during frame" : "R3 hold drops on bad length", int'(radio_hold), int'(ok));
        if (ok) begin
            for (int i = 0; i < len; i++) begin
                c = crc_bits(c, pb(seed, i));
                send_byte(pb(seed, i));
            end
            if (badcrc) c = c ^ 16'h0001;
            send_byte(c[15:8]);
            send_byte(c[7:0]);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_check(input string req, input logic [7:0] exp);
        check(req, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_flags();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 hold", int'(radio_hold), 0);
        check("R1 irq", int'(rx_irq), 0);
        check("R1 ovf", int'(rx_ovf), 0);
        check("R1 count", int'(fifo_count), 0);

        foreach (VECS[k]) begin
            addr_en = VECS[k].aen;
            send_frame(VECS[k].len, VECS[k].seed, VECS[k].badcrc);
            check("R6 R4 R5 count after frame", int'(fifo_count), VECS[k].keep ? int'(VECS[k].len) : 0);
            check("R6 R4 R5 irq after frame", int'(rx_irq), int'(VECS[k].keep));
            check("R2 hold low after frame", int'(radio_hold), 0);
            if (VECS[k].keep)
                for (int i = 0; i < VECS[k].len; i++) pop_check("R6 R8 payload order", pb(VECS[k].seed, i));
            clear_flags();
            check("R9 irq cleared", int'(rx_irq), 0);
        end
        addr_en = 1'b0;

        // R3 illegal lengths
        send_frame(8'd0, 8'h00, 1'b0);
        check("R3 count after zero length", int'(fifo_count), 0);
        check("R3 irq after zero length", int'(rx_irq), 0);
        send_frame(8'd200, 8'h00, 1'b0);
        check("R3 count after long length", int'(fifo_count), 0);
        check("R3 irq after long length", int'(rx_irq), 0);
        send_frame(8'd128, 8'h00, 1'b0);
        check("R3 count after length 128", int'(fifo_count), 0);

        // R8 two frames accumulate, committed count, order kept
        send_frame(8'd2, 8'h40, 1'b0);
        send_frame(8'd3, 8'h50, 1'b0);
        check("R8 count after two frames", int'(fifo_count), 5);
        for (int i = 0; i < 2; i++) pop_check("R8 first frame bytes", pb(8'h40, i));
        for (int i = 0; i < 3; i++) pop_check("R8 second frame bytes", pb(8'h50, i));
        check("R8 count drained", int'(fifo_count), 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 pop on empty ignored", int'(fifo_count), 0);
        clear_flags();

        // R7 overflow: 70 bytes into a 64-byte FIFO
        send_frame(8'd70, 8'h07, 1'b0);
        check("R7 ovf flag", int'(rx_ovf), 1);
        check("R7 count after overflow", int'(fifo_count), 0);
        check("R7 irq after overflow", int'(rx_irq), 0);
        clear_flags();
        check("R9 ovf cleared", int'(rx_ovf), 0);

        // R7 FIFO usable again after overflow discard
        send_frame(8'd64, 8'h09, 1'b0);
        check("R7 full frame fits", int'(fifo_count), 64);
        check("R7 no ovf at exact fill", int'(rx_ovf), 0);
        pop_check("R8 first byte after refill", pb(8'h09, 0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule